// File: doc/BRIEF.md
# Presettable Down Counter Stage

This block is a four-bit down counter for divide-by-N work. It sits in one system clock domain. Two asynchronous control lines are brought into that domain, a count tick and an inhibit line. A rising tick decrements the count while inhibit is low. With the tick held high, a falling inhibit line also acts as the count strobe. A parameter picks the wrap behaviour at zero: binary wraps to fifteen, and decimal wraps to nine.

A parallel value is loaded while the load enable is high, and it is held for as long as that level stays high. The clear input empties the counter and wins over every other input. The zero detect output is combinational. When the chain feedback input is high, it reports a zero count. When chain feedback is low, it copies the load enable. In a single stage the zero detect output can therefore be wired straight back to the load enable, which makes the stage reload itself every N ticks.

Top module: `dncnt_stage`

## Requirements
- R1: While `clr` is high, `cnt` is 0 whatever the other inputs do. During that time `at_zero` is 1 when `chain_fb` is 1.
- R2: With `clr` low, `load_en` high copies `load_val` into `cnt` (bit 0 is the least significant bit). The value is held there, and ticks arriving during the load are ignored.
- R3: With `clr`, `load_en` and `inhibit` low, a rising `tick_in` lowers `cnt` by one. The new value is visible after the third rising `clk` edge that follows the input change.
- R4: While `inhibit` is high, rising edges on `tick_in` leave `cnt` unchanged.
- R5: While `tick_in` is high, a falling edge on `inhibit` lowers `cnt` by one.
- R6: With RADIX binary, each decrement gives (cnt − 1) mod 16, so 0 steps to 15.
- R7: With RADIX decimal, a decrement from 0 gives 9.
- R8: With RADIX decimal, a loaded value from 10 to 15 counts down in binary until it enters the 9-to-0 cycle.
- R9: With `chain_fb` high, `at_zero` is 1 exactly when `cnt` is 0.
- R10: With `chain_fb` low, `at_zero` equals `load_en`.
- R11: A rising `inhibit` or a falling `tick_in` alone never changes `cnt`.
- R12: When `clr` is released, a `tick_in` that is already high does not cause a decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous clear, active high |
| tick_in | input | 1 | Count tick, asynchronous; the rising edge counts |
| inhibit | input | 1 | Blocks tick counting; its falling edge counts while the tick is high |
| load_en | input | 1 | Level load enable |
| load_val | input | CNT_W | Parallel load value |
| chain_fb | input | 1 | Selects what the zero detect reports |
| cnt | output | CNT_W | Current count |
| at_zero | output | 1 | Zero detect |

## Verification
The bench builds two copies with CNT_W=4 and two synchroniser stages, one in binary mode and one in decimal mode, and drives both from the same stimulus. Every load value from 0 to 15 is counted down for twenty strobes. This covers each wrap at zero, the binary run-down of decimal-mode values above nine, and the zero detect at every count. Every third strobe uses the inhibit path, so the blocked-tick and falling-inhibit cases are both exercised. Separate short sequences cover clear override, load hold, the decrement latency and tick behaviour at clear release.

// File: rtl/dncnt_pkg.sv
package dncnt_pkg;
   typedef enum logic {
      RADIX_BIN = 1'b0,
      RADIX_DEC = 1'b1
   } radix_e;
endpackage

// File: rtl/dncnt_sync.sv
module dncnt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic clr,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dncnt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge clr) begin
      if (clr) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dncnt_strobe.sv
module dncnt_strobe #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic clr,
   input  logic tick_s,
   input  logic inh_s,
   output logic step
);
   localparam int GUARD_INIT = STAGES + 1;
   localparam int GW = $clog2(GUARD_INIT + 1);

   logic          tick_q, inh_q;
   logic [GW-1:0] guard;
   logic          rise, fall;

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         tick_q <= 1'b0;
         inh_q  <= 1'b0;
         guard  <= GW'(GUARD_INIT);
      end else begin
         tick_q <= tick_s;
         inh_q  <= inh_s;
         if (guard != '0) guard <= guard - GW'(1);
      end
   end

   assign rise = tick_s & ~tick_q;
   assign fall = ~inh_s & inh_q;
   assign step = (guard == '0) & ((rise & ~inh_s) | (fall & tick_s));

   // R4: an inhibit held high over two samples lets no tick through
   assert_inhibit_blocks_R4: assert property (@(posedge clk) disable iff (clr)
      (inh_s && inh_q) |-> !step);
endmodule

// File: rtl/dncnt_core.sv
module dncnt_core
   import dncnt_pkg::*;
#(
   parameter radix_e RADIX = RADIX_BIN,
   parameter int     CNT_W = 4
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] WRAP_VAL =
      (RADIX == RADIX_DEC) ? CNT_W'(9) : {CNT_W{1'b1}};

   logic [CNT_W-1:0] nxt;

   generate
      if (RADIX == RADIX_DEC) begin : g_dec
         if (CNT_W != 4) begin : g_bad_width
            $error("dncnt_core: decimal radix needs CNT_W of 4");
         end
         assign nxt = (cnt == '0) ? WRAP_VAL : cnt - CNT_W'(1);
      end else begin : g_bin
         assign nxt = cnt - CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or posedge clr) begin
      if (clr)       cnt <= '0;
      else if (load) cnt <= load_val;
      else if (step) cnt <= nxt;
   end

   always @(posedge clk) begin
      if (clr) assert_clear_R1: assert (cnt == '0);
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (clr)
      load |=> cnt == $past(load_val));

   assert_step_R3: assert property (@(posedge clk) disable iff (clr)
      (step && !load && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

   assert_wrap_R6_R7: assert property (@(posedge clk) disable iff (clr)
      (step && !load && cnt == '0) |=> cnt == WRAP_VAL);

   assert_hold_R11: assert property (@(posedge clk) disable iff (clr)
      (!step && !load) |=> $stable(cnt));
endmodule

// File: rtl/dncnt_stage.sv
module dncnt_stage
   import dncnt_pkg::*;
#(
   parameter radix_e RADIX       = RADIX_BIN,
   parameter int     CNT_W       = 4,
   parameter int     SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             tick_in,
   input  logic             inhibit,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             chain_fb,
   output logic [CNT_W-1:0] cnt,
   output logic             at_zero
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("dncnt_stage: CNT_W must be at least 2");
      end
   endgenerate

   logic tick_s, inh_s, step;

   dncnt_sync #(.STAGES(SYNC_STAGES)) u_sync_tick (
      .clk(clk), .clr(clr), .d(tick_in), .q(tick_s));

   dncnt_sync #(.STAGES(SYNC_STAGES)) u_sync_inh (
      .clk(clk), .clr(clr), .d(inhibit), .q(inh_s));

   dncnt_strobe #(.STAGES(SYNC_STAGES)) u_strobe (
      .clk(clk), .clr(clr), .tick_s(tick_s), .inh_s(inh_s), .step(step));

   dncnt_core #(.RADIX(RADIX), .CNT_W(CNT_W)) u_core (
      .clk(clk), .clr(clr), .load(load_en), .load_val(load_val),
      .step(step), .cnt(cnt));

   assign at_zero = chain_fb ? (cnt == '0) : load_en;

   always @(posedge clk) begin
      if (clr && chain_fb) assert_clear_flag_R1: assert (at_zero);
   end

   // R9: once the count sits at zero with feedback high, the flag stays up until a step or load
   assert_zero_flag_R9: assert property (@(posedge clk) disable iff (clr)
      (chain_fb && at_zero && !step && !load_en) |=> (!chain_fb || at_zero));
endmodule

// File: tb/sim_dncnt_stage.sv
module sim_dncnt_stage;
   import dncnt_pkg::*;

   logic       clk = 1'b0;
   logic       clr, tick_in, inhibit, load_en, chain_fb;
   logic [3:0] load_val;
   logic [3:0] cb, cd;
   logic       zb, zd;
   int         n_cmp = 0;
   int         n_bad = 0;

   always #4 clk = ~clk;

   dncnt_stage #(.RADIX(RADIX_BIN), .CNT_W(4), .SYNC_STAGES(2)) u0 (
      .clk(clk), .clr(clr), .tick_in(tick_in), .inhibit(inhibit),
      .load_en(load_en), .load_val(load_val), .chain_fb(chain_fb),
      .cnt(cb), .at_zero(zb));

   dncnt_stage #(.RADIX(RADIX_DEC), .CNT_W(4), .SYNC_STAGES(2)) u1 (
      .clk(clk), .clr(clr), .tick_in(tick_in), .inhibit(inhibit),
      .load_en(load_en), .load_val(load_val), .chain_fb(chain_fb),
      .cnt(cd), .at_zero(zd));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int exp_bin(input int p, input int k);
      return (p - k) & 15;
   endfunction

   function automatic int exp_dec(input int p, input int k);
      if (k <= p) return p - k;
      return 9 - ((k - p - 1) % 10);
   endfunction

   task automatic clk_step();
      tick_in = 1'b1; tick(4);
      tick_in = 1'b0; tick(4);
   endtask

   task automatic inh_step(input int eb, input int ed);
      inhibit = 1'b1; tick(4);
      chk("R11 inhibit rise bin", cb, eb);
      chk("R11 inhibit rise dec", cd, ed);
      tick_in = 1'b1; tick(4);
      chk("R4 blocked tick bin", cb, eb);
      chk("R4 blocked tick dec", cd, ed);
      inhibit = 1'b0; tick(4);
      tick_in = 1'b0; tick(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      clr = 1'b1; tick_in = 1'b0; inhibit = 1'b0; load_en = 1'b0;
      load_val = 4'd0; chain_fb = 1'b1;
      tick(3);
      chk("R1 reset cnt bin", cb, 0);
      chk("R1 reset cnt dec", cd, 0);
      chk("R1 reset flag", zb, 1);
      load_val = 4'd5; load_en = 1'b1; tick(3);
      chk("R1 clear beats load", cb, 0);
      clk_step();
      chk("R1 clear beats tick", cd, 0);
      chain_fb = 1'b0; tick(1);
      chk("R10 flag follows load high", zb, 1);
      load_en = 1'b0; tick(1);
      chk("R10 flag follows load low", zb, 0);
      chain_fb = 1'b1;

      // R12: tick already high at clear release
      tick_in = 1'b1; tick(2);
      clr = 1'b0; tick(8);
      chk("R12 no step at release bin", cb, 0);
      chk("R12 no step at release dec", cd, 0);
      tick_in = 1'b0; tick(6);

      // R3 latency
      load_val = 4'd3; load_en = 1'b1; tick(2);
      load_en = 1'b0; tick(2);
      tick_in = 1'b1; tick(2);
      chk("R3 before third edge", cb, 3);
      tick(1);
      chk("R3 after third edge", cb, 2);
      tick(1); tick_in = 1'b0; tick(4);

      // R10 with nonzero count
      chain_fb = 1'b0; load_val = 4'd7; load_en = 1'b1; tick(2);
      chk("R10 flag with load high", zd, 1);
      load_en = 1'b0; tick(1);
      chk("R10 flag with load low", zd, 0);
      chain_fb = 1'b1;

      for (int p = 0; p < 16; p++) begin
         load_val = 4'(p); load_en = 1'b1; tick(2);
         chk("R2 load bin", cb, p);
         chk("R2 load dec", cd, p);
         clk_step();
         chk("R2 held during tick", cb, p);
         chk("R9 flag after load", zb, (p == 0) ? 1 : 0);
         load_en = 1'b0; tick(1);
         for (int k = 1; k <= 20; k++) begin
            int eb, ed;
            eb = exp_bin(p, k);
            ed = exp_dec(p, k);
            if (k % 3 == 0) begin
               inh_step(exp_bin(p, k - 1), exp_dec(p, k - 1));
               chk("R5 inhibit strobe bin", cb, eb);
               chk("R5 inhibit strobe dec", cd, ed);
            end else begin
               clk_step();
               chk("R6 R3 binary step", cb, eb);
               if (p > 9 && k <= p) chk("R8 decimal above nine", cd, ed);
               else                 chk("R7 decimal step", cd, ed);
            end
            chk("R9 flag bin", zb, (eb == 0) ? 1 : 0);
            chk("R9 flag dec", zd, (ed == 0) ? 1 : 0);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule